// File: doc/BRIEF.md
# Fixed-Priority Interrupt Vector Controller

This block gathers every interrupt request of a small microcontroller core and turns them into one vector address for the CPU. There are three classes of request. Reset-class requests are the power-up, reset-pin, watchdog-timeout and flash-key lines, plus a fetch from an illegal address. Non-maskable requests each have their own enable bit, and the general interrupt enable does not gate them. Maskable peripheral requests need both their own enable bit and the general enable. Each request owns one of 32 priority slots. The vector of slot `s` is the word address `16'hFFC0 + 2*s`, so the highest slot (31) sits at `16'hFFFE`.

Each cycle the qualified requests are registered into a pending vector, and a combinational priority encoder picks the highest pending slot. When the block is idle and something is pending, it captures that slot. It then raises `irqReq` and holds `vecAddr` steady until the CPU pulses `ack`. A reset-class request overrides everything: it drops any held vector, shows `16'hFFFE` and raises `resetReq` for as long as the request stays present. When the CPU acknowledges a non-maskable vector, the block pulses `gieClear` for one cycle so the CPU can drop its general enable.

Top module: `irq_vector_ctrl`

## Requirements
- R1: A request sampled at clock edge k appears on the outputs after edge k+1. A held vector is always `16'hFFC0 + 2*slot`, word aligned, in the range `16'hFFC0`..`16'hFFFE`.
- R2: Any bit of `rstSrc` raises `resetReq` with `vecAddr = 16'hFFFE`. No enable bit affects this, and `resetReq` falls once the source is gone.
- R3: With `fetchValid` high, an address outside the three legal windows raises a reset request. The legal windows are RAM `16'h0200`..`16'h03FF`, info `16'h1000`..`16'h10FF` and code `16'hC000`..`16'hFFFF`, so `16'h0000`..`16'h01FF` is illegal. A fetch inside a legal window does not raise a reset request.
- R4: Non-maskable request `nmiSrc[i]` takes the vector `16'hFFFC` when `nmiEn[i]` is 1, whatever the value of `gie`. When `nmiEn[i]` is 0 it is ignored.
- R5: Maskable request `maskSrc[i]` is taken only when both `maskEn[i]` and `gie` are 1.
- R6: Maskable priority runs from highest to lowest through these indices and vectors: 0 `FFFA`, 1 `FFF8`, 2 `FFF4`, 3 `FFF2`, 4 `FFF0`, 5 `FFEE`, 6 `FFEC`, 7 `FFEA`, 8 `FFE6`, 9 `FFE4`. All of them rank below the non-maskable slot, and the reset slot ranks above everything.
- R7: Maskable index 2 (the watchdog interval source) counts as enabled only while `wdtInterval` is 1.
- R8: While `irqReq` is high and `ack` is low, `vecAddr` does not change, even if a higher maskable or non-maskable request arrives. The only exception is a reset-class request.
- R9: `gieClear` pulses for exactly one cycle after an `ack` of the `16'hFFFC` vector. It stays low after an `ack` of any other vector.
- R10: A reset request drops the held vector. `irqReq` is never high while `resetReq` is high.
- R11: After reset: `irqReq`, `resetReq` and `gieClear` are 0 and `vecAddr` is `16'hFFFE`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| rstSrc | input | 4 | Reset-class request lines |
| nmiSrc | input | 3 | Non-maskable request lines |
| nmiEn | input | 3 | Per-line enables for nmiSrc |
| maskSrc | input | 10 | Maskable request lines, index 0 highest |
| maskEn | input | 10 | Per-line enables for maskSrc |
| gie | input | 1 | General interrupt enable |
| wdtInterval | input | 1 | Watchdog in interval-timer mode |
| fetchValid | input | 1 | An instruction fetch is in progress |
| fetchAddr | input | 16 | Address of that fetch |
| ack | input | 1 | CPU has taken the presented vector |
| irqReq | output | 1 | Interrupt request, held until ack |
| vecAddr | output | 16 | Vector word address |
| resetReq | output | 1 | Reset request |
| gieClear | output | 1 | One-cycle pulse after a non-maskable vector is taken |

## Verification
The two functions that collide are the hold of an unacknowledged vector and the arrival of a new request. The new request may be a higher-ranked interrupt, which must wait, or a reset-class event, which must win at once. The bench holds a low-priority vector and then raises a higher maskable line: it checks that the vector stays frozen over several cycles and that the newer vector appears right after `ack`. It then raises a reset source while a vector is held and checks that `resetReq`, `irqReq` and `vecAddr` switch together. The random trials cover the same overlaps by setting several classes in the same cycle and comparing the result with a priority model in the bench.

// File: rtl/ivc_pkg.sv
package ivc_pkg;
  localparam int NUM_SLOTS = 32;
  localparam int SLOT_W    = $clog2(NUM_SLOTS);
  localparam int ADDR_W    = 16;
  localparam int RST_SLOT  = NUM_SLOTS - 1;
  localparam int NMI_SLOT  = NUM_SLOTS - 2;
  localparam int NUM_RST   = 4;
  localparam int NUM_NMI   = 3;
  localparam int NUM_MASK  = 10;
  localparam int WDT_IDX   = 2;
  localparam logic [ADDR_W-1:0] VEC_BASE = 16'hFFC0;

  // slot owned by each maskable line, index 0 ranks highest
  localparam int MASK_SLOT [NUM_MASK] = '{29, 28, 26, 25, 24, 23, 22, 21, 19, 18};

  typedef struct packed {
    logic capture;   // latch the encoder output into the held slot
    logic forceRst;  // overwrite the held slot with the reset slot
  } ivcStrobe_t;
endpackage

// File: rtl/ivc_datapath.sv
module ivc_datapath
  import ivc_pkg::*;
#(
  parameter logic [ADDR_W-1:0] RAM_BASE  = 16'h0200,
  parameter logic [ADDR_W-1:0] RAM_LAST  = 16'h03FF,
  parameter logic [ADDR_W-1:0] INFO_BASE = 16'h1000,
  parameter logic [ADDR_W-1:0] INFO_LAST = 16'h10FF,
  parameter logic [ADDR_W-1:0] CODE_BASE = 16'hC000
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_RST-1:0]  rstSrc,
  input  logic [NUM_NMI-1:0]  nmiSrc,
  input  logic [NUM_NMI-1:0]  nmiEn,
  input  logic [NUM_MASK-1:0] maskSrc,
  input  logic [NUM_MASK-1:0] maskEn,
  input  logic                gie,
  input  logic                wdtInterval,
  input  logic                fetchValid,
  input  logic [ADDR_W-1:0]   fetchAddr,
  input  ivcStrobe_t          strobe,
  output logic                rstPend,
  output logic                anyPend,
  output logic                heldIsNmi,
  output logic [ADDR_W-1:0]   vecAddr
);
  logic [NUM_SLOTS-1:0] pendNext;
  logic [NUM_SLOTS-1:0] pendReg;
  logic [NUM_MASK-1:0]  maskQual;
  logic [SLOT_W-1:0]    selSlot;
  logic [SLOT_W-1:0]    holdSlot;
  logic                 fetchLegal;
  logic                 fetchBad;

  // fetch window check
  assign fetchLegal = ((fetchAddr >= RAM_BASE)  && (fetchAddr <= RAM_LAST))  ||
                      ((fetchAddr >= INFO_BASE) && (fetchAddr <= INFO_LAST)) ||
                      (fetchAddr >= CODE_BASE);
  assign fetchBad   = fetchValid && !fetchLegal;

  // per-line qualification of maskable requests
  for (genvar i = 0; i < NUM_MASK; i++) begin : g_mask
    if (i == WDT_IDX) begin : g_wdt
      assign maskQual[i] = maskSrc[i] & maskEn[i] & gie & wdtInterval;
    end else begin : g_plain
      assign maskQual[i] = maskSrc[i] & maskEn[i] & gie;
    end
  end

  always_comb begin
    pendNext           = '0;
    pendNext[RST_SLOT] = (|rstSrc) | fetchBad;
    pendNext[NMI_SLOT] = |(nmiSrc & nmiEn);
    for (int i = 0; i < NUM_MASK; i++) begin
      pendNext[MASK_SLOT[i]] = maskQual[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) pendReg <= '0;
    else       pendReg <= pendNext;
  end

  // fixed-priority encoder, highest index wins
  always_comb begin
    selSlot = '0;
    for (int s = 0; s < NUM_SLOTS; s++) begin
      if (pendReg[s]) selSlot = SLOT_W'(s);
    end
  end

  assign anyPend = |pendReg;
  assign rstPend = pendReg[RST_SLOT];

  always_ff @(posedge clk) begin
    if (!rstN)                 holdSlot <= SLOT_W'(RST_SLOT);
    else if (strobe.forceRst)  holdSlot <= SLOT_W'(RST_SLOT);
    else if (strobe.capture)   holdSlot <= selSlot;
  end

  assign heldIsNmi = (holdSlot == SLOT_W'(NMI_SLOT));
  assign vecAddr   = VEC_BASE + ADDR_W'({holdSlot, 1'b0});
endmodule

// File: rtl/ivc_control.sv
module ivc_control
  import ivc_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       ack,
  input  logic       rstPend,
  input  logic       anyPend,
  input  logic       heldIsNmi,
  output ivcStrobe_t strobe,
  output logic       holdValid,
  output logic       rstActive,
  output logic       gieClear
);
  always_comb begin
    strobe = '0;
    if (rstPend)                     strobe.forceRst = 1'b1;
    else if (!holdValid && anyPend)  strobe.capture  = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      holdValid <= 1'b0;
      rstActive <= 1'b0;
      gieClear  <= 1'b0;
    end else begin
      rstActive <= rstPend;
      gieClear  <= 1'b0;
      if (rstPend) begin
        holdValid <= 1'b0;
      end else if (holdValid) begin
        if (ack) begin
          holdValid <= 1'b0;
          gieClear  <= heldIsNmi;
        end
      end else if (anyPend) begin
        holdValid <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
  import ivc_pkg::*;
#(
  parameter logic [ADDR_W-1:0] RAM_BASE  = 16'h0200,
  parameter logic [ADDR_W-1:0] RAM_LAST  = 16'h03FF,
  parameter logic [ADDR_W-1:0] INFO_BASE = 16'h1000,
  parameter logic [ADDR_W-1:0] INFO_LAST = 16'h10FF,
  parameter logic [ADDR_W-1:0] CODE_BASE = 16'hC000
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_RST-1:0]  rstSrc,
  input  logic [NUM_NMI-1:0]  nmiSrc,
  input  logic [NUM_NMI-1:0]  nmiEn,
  input  logic [NUM_MASK-1:0] maskSrc,
  input  logic [NUM_MASK-1:0] maskEn,
  input  logic                gie,
  input  logic                wdtInterval,
  input  logic                fetchValid,
  input  logic [ADDR_W-1:0]   fetchAddr,
  input  logic                ack,
  output logic                irqReq,
  output logic [ADDR_W-1:0]   vecAddr,
  output logic                resetReq,
  output logic                gieClear
);
  ivcStrobe_t strobe;
  logic       rstPend;
  logic       anyPend;
  logic       heldIsNmi;
  logic       holdValid;
  logic       rstActive;

  ivc_datapath #(
    .RAM_BASE (RAM_BASE),
    .RAM_LAST (RAM_LAST),
    .INFO_BASE(INFO_BASE),
    .INFO_LAST(INFO_LAST),
    .CODE_BASE(CODE_BASE)
  ) uData (
    .clk        (clk),
    .rstN       (rstN),
    .rstSrc     (rstSrc),
    .nmiSrc     (nmiSrc),
    .nmiEn      (nmiEn),
    .maskSrc    (maskSrc),
    .maskEn     (maskEn),
    .gie        (gie),
    .wdtInterval(wdtInterval),
    .fetchValid (fetchValid),
    .fetchAddr  (fetchAddr),
    .strobe     (strobe),
    .rstPend    (rstPend),
    .anyPend    (anyPend),
    .heldIsNmi  (heldIsNmi),
    .vecAddr    (vecAddr)
  );

  ivc_control uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .ack      (ack),
    .rstPend  (rstPend),
    .anyPend  (anyPend),
    .heldIsNmi(heldIsNmi),
    .strobe   (strobe),
    .holdValid(holdValid),
    .rstActive(rstActive),
    .gieClear (gieClear)
  );

  assign irqReq   = holdValid;
  assign resetReq = rstActive;
endmodule

// File: rtl/ivc_checker.sv
module ivc_checker (
  input logic        clk,
  input logic        rstN,
  input logic        ack,
  input logic        irqReq,
  input logic [15:0] vecAddr,
  input logic        resetReq,
  input logic        gieClear,
  input logic        rstPend
);
  // R10: reset and interrupt request never overlap
  a_r10_reset_excl: assert property (@(posedge clk) disable iff (!rstN)
    resetReq |-> !irqReq);

  // R2: reset request shows the top vector
  a_r2_reset_vec: assert property (@(posedge clk) disable iff (!rstN)
    resetReq |-> vecAddr == 16'hFFFE);

  // R2: a registered reset-class request always reaches the output
  a_r2_pend_to_reset: assert property (@(posedge clk) disable iff (!rstN)
    rstPend |=> resetReq);

  // R8: held vector is frozen until ack
  a_r8_hold: assert property (@(posedge clk) disable iff (!rstN)
    (irqReq && !ack && !rstPend) |=> (irqReq && $stable(vecAddr)));

  // R9: gieClear follows an ack of the non-maskable vector
  a_r9_gie_clear: assert property (@(posedge clk) disable iff (!rstN)
    gieClear |-> $past(irqReq && ack && vecAddr == 16'hFFFC));

  // R9: gieClear is a single-cycle pulse
  a_r9_pulse: assert property (@(posedge clk) disable iff (!rstN)
    gieClear |=> !gieClear);

  // R1: presented vector lies in the table and is word aligned
  a_r1_vec_range: assert property (@(posedge clk) disable iff (!rstN)
    irqReq |-> (vecAddr[15:6] == 10'h3FF && !vecAddr[0]));
endmodule

bind irq_vector_ctrl ivc_checker uChk (
  .clk     (clk),
  .rstN    (rstN),
  .ack     (ack),
  .irqReq  (irqReq),
  .vecAddr (vecAddr),
  .resetReq(resetReq),
  .gieClear(gieClear),
  .rstPend (rstPend)
);

// File: tb/irq_vector_ctrl_test.sv
`timescale 1ns/1ps
module irq_vector_ctrl_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [3:0]  rstSrc = '0;
  logic [2:0]  nmiSrc = '0;
  logic [2:0]  nmiEn = '0;
  logic [9:0]  maskSrc = '0;
  logic [9:0]  maskEn = '0;
  logic        gie = 1'b0;
  logic        wdtInterval = 1'b0;
  logic        fetchValid = 1'b0;
  logic [15:0] fetchAddr = '0;
  logic        ack = 1'b0;
  logic        irqReq;
  logic [15:0] vecAddr;
  logic        resetReq;
  logic        gieClear;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  irq_vector_ctrl uut (
    .clk(clk), .rstN(rstN), .rstSrc(rstSrc), .nmiSrc(nmiSrc), .nmiEn(nmiEn),
    .maskSrc(maskSrc), .maskEn(maskEn), .gie(gie), .wdtInterval(wdtInterval),
    .fetchValid(fetchValid), .fetchAddr(fetchAddr), .ack(ack),
    .irqReq(irqReq), .vecAddr(vecAddr), .resetReq(resetReq), .gieClear(gieClear)
  );

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // R6 table of maskable vectors, index 0 highest
  function automatic logic [15:0] maskVec(int i);
    case (i)
      0: return 16'hFFFA;  1: return 16'hFFF8;  2: return 16'hFFF4;
      3: return 16'hFFF2;  4: return 16'hFFF0;  5: return 16'hFFEE;
      6: return 16'hFFEC;  7: return 16'hFFEA;  8: return 16'hFFE6;
      default: return 16'hFFE4;
    endcase
  endfunction

  // R3 legal windows
  function automatic logic fetchIllegal(logic v, logic [15:0] a);
    logic ok;
    ok = (a >= 16'h0200 && a <= 16'h03FF) || (a >= 16'h1000 && a <= 16'h10FF) ||
         (a >= 16'hC000);
    return v && !ok;
  endfunction

  function automatic void model(output logic eRst, output logic eIrq, output logic [15:0] eVec);
    eRst = (|rstSrc) || fetchIllegal(fetchValid, fetchAddr);
    eIrq = 1'b0;
    eVec = 16'hFFFE;
    if (eRst) return;
    if (|(nmiSrc & nmiEn)) begin
      eIrq = 1'b1; eVec = 16'hFFFC; return;
    end
    for (int i = 0; i < 10; i++) begin
      if (maskSrc[i] && maskEn[i] && gie && (i != 2 || wdtInterval)) begin
        eIrq = 1'b1; eVec = maskVec(i); return;
      end
    end
  endfunction

  task automatic clearSrc();
    rstSrc = '0; nmiSrc = '0; maskSrc = '0; fetchValid = 1'b0;
  endtask

  // inputs are set by the caller just after a falling edge
  task automatic runCase(string tag);
    logic eRst, eIrq;
    logic [15:0] eVec;
    model(eRst, eIrq, eVec);
    @(negedge clk); @(negedge clk);
    check(tag, "resetReq", resetReq, eRst);
    check(tag, "irqReq", irqReq, eIrq);
    if (eRst || eIrq) check(tag, "vecAddr", vecAddr, eVec);
    @(negedge clk);
    if (eIrq) check("R8", "vecAddr stable", vecAddr, eVec);
    clearSrc();
    ack = 1'b1;
    @(negedge clk);
    check("R9", "gieClear after ack", gieClear, eIrq && eVec == 16'hFFFC);
    ack = 1'b0;
    @(negedge clk);
    check("R9", "gieClear pulse end", gieClear, 1'b0);
    check("R2", "idle resetReq", resetReq, 1'b0);
    check("R1", "idle irqReq", irqReq, 1'b0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] addrs [11];
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R11 reset state
    check("R11", "irqReq", irqReq, 1'b0);
    check("R11", "resetReq", resetReq, 1'b0);
    check("R11", "gieClear", gieClear, 1'b0);
    check("R11", "vecAddr", vecAddr, 16'hFFFE);

    // R2 each reset source, enables all low
    for (int i = 0; i < 4; i++) begin
      gie = 1'b0; nmiEn = '0; maskEn = '0;
      rstSrc = 4'(1 << i);
      runCase("R2");
    end

    // R3 fetch boundaries
    addrs = '{16'h0000, 16'h01FF, 16'h0200, 16'h03FF, 16'h0400, 16'h0FFF,
              16'h1000, 16'h10FF, 16'h1100, 16'hBFFF, 16'hC000};
    foreach (addrs[k]) begin
      fetchValid = 1'b1; fetchAddr = addrs[k];
      runCase("R3");
    end

    // R6 single lines and adjacent pairs
    gie = 1'b1; maskEn = '1; nmiEn = '1; wdtInterval = 1'b1;
    for (int i = 0; i < 10; i++) begin
      maskSrc = 10'(1 << i);
      runCase("R6");
    end
    for (int i = 0; i < 9; i++) begin
      maskSrc = 10'(3 << i);
      runCase("R6");
    end
    nmiSrc = 3'b100; maskSrc = '1;
    runCase("R6");

    // R4 non-maskable ignores gie, obeys own enable
    gie = 1'b0; nmiSrc = 3'b010; nmiEn = 3'b010;
    runCase("R4");
    nmiSrc = 3'b010; nmiEn = 3'b101; maskSrc = '1;
    runCase("R4");

    // R5 maskable needs both enables
    gie = 1'b0; nmiEn = '1; maskEn = '1; maskSrc = 10'b0000100000;
    runCase("R5");
    gie = 1'b1; maskEn = 10'b1111011111; maskSrc = 10'b0000100000;
    runCase("R5");
    maskEn = 10'b1111011111; maskSrc = 10'b0001100000;
    runCase("R5");

    // R7 watchdog line depends on interval mode
    maskEn = '1; wdtInterval = 1'b0; maskSrc = 10'b0000000100;
    runCase("R7");
    wdtInterval = 1'b0; maskSrc = 10'b0000010100;
    runCase("R7");
    wdtInterval = 1'b1; maskSrc = 10'b0000000100;
    runCase("R7");

    // R8 hold against a higher request, then release on ack
    maskSrc = 10'b1000000000;
    @(negedge clk); @(negedge clk);
    check("R8", "first vector", vecAddr, 16'hFFE4);
    maskSrc = 10'b1000000001; nmiSrc = 3'b001;
    for (int c = 0; c < 4; c++) begin
      @(negedge clk);
      check("R8", "vector frozen", vecAddr, 16'hFFE4);
      check("R8", "irq held", irqReq, 1'b1);
    end
    nmiSrc = '0; maskSrc = 10'b0000000001; ack = 1'b1;
    @(negedge clk);
    check("R9", "no gieClear for maskable", gieClear, 1'b0);
    ack = 1'b0;
    @(negedge clk);
    check("R8", "next vector after ack", vecAddr, 16'hFFFA);
    check("R8", "irq after ack", irqReq, 1'b1);

    // R10 reset preempts the held vector
    rstSrc = 4'b0010;
    @(negedge clk); @(negedge clk);
    check("R10", "resetReq", resetReq, 1'b1);
    check("R10", "irqReq dropped", irqReq, 1'b0);
    check("R10", "vecAddr", vecAddr, 16'hFFFE);
    clearSrc();
    @(negedge clk); @(negedge clk);
    check("R10", "resetReq released", resetReq, 1'b0);
    check("R10", "held vector gone", irqReq, 1'b0);

    // random mix of all classes
    for (int t = 0; t < 400; t++) begin
      rstSrc      = ($urandom % 10 == 0) ? 4'(1 << ($urandom % 4)) : 4'b0;
      nmiSrc      = ($urandom % 3 == 0) ? 3'($urandom) : 3'b0;
      nmiEn       = 3'($urandom);
      maskSrc     = 10'($urandom & $urandom);
      maskEn      = 10'($urandom | $urandom);
      gie         = ($urandom % 4 != 0);
      wdtInterval = 1'($urandom);
      fetchValid  = ($urandom % 5 == 0);
      fetchAddr   = 16'($urandom);
      runCase("R1");
    end

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule